// File: doc/BRIEF.md
# Maskable Latched Interrupt Controller

The block gathers up to 32 interrupt lines into a single interrupt request for a processor. Every line passes through a two-flop synchroniser. A trigger stage then turns it into a set pulse: a rising edge for lines configured as edge lines, and the plain high level for lines configured as level lines. Each set pulse latches a sticky pending bit in a status register. The bit stays set until software acknowledges it, and this holds for level lines too.

A mask register decides which pending bits may reach the processor. The request output is registered. It asserts when any pending bit is also unmasked and the processor's global interrupt enable input is high. Software reads both registers over a small register port. It changes one mask bit by reading the mask, modifying it and writing it back. It acknowledges pending bits by writing the status register. A parameter selects how the acknowledge works: either written ones clear bits, or written zeros clear bits. To find pending lines, software scans the status value upward from bit 0.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset the mask register reads 0 and the status register reads 0. While a line is masked, its pending bit never drives `irq_o`.
- R2: A register write with `reg_sel_i` = 0 replaces the whole mask with `reg_wdata_i`. A read with `reg_sel_i` = 0 returns the mask value.
- R3: On an edge line (lines 0 to 15 by default), a rising input latches pending bit n. The bit stays set after the input falls. If the bit is cleared while the input is held high, it does not set again.
- R4: In write-one-clear mode (`ACK_MODE` = ACK_W1C), a status write (`reg_sel_i` = 1) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: `irq_o` is registered. It rises on the clock edge after an unmasked pending bit appears. It falls on the clock edge after the last unmasked pending bit clears.
- R6: While `gie_i` is low, `irq_o` is low on the following cycle, whatever is pending.
- R7: On a level line (lines 16 to 31 by default), a high input latches its pending bit. The bit stays set after the input drops and clears only through an acknowledge.
- R8: A status read returns every latched bit, masked or not.
- R9: If a set pulse and a software clear reach the same bit in the same cycle, the bit stays set.
- R10: In write-zero-clear mode (`ACK_MODE` = ACK_W0C), a status write clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R11: An input change reaches the status register on the third rising clock edge after it is applied, because of two synchroniser flops and the status flop.
- R12: Status bit n belongs to input line n. Several lines that rise together are all latched at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_IRQ | Asynchronous interrupt lines, bit n is line n |
| gie_i | input | 1 | Global interrupt enable from the processor status |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 is mask, 1 is status |
| reg_wdata_i | input | NUM_IRQ | Register write data |
| reg_rdata_o | output | NUM_IRQ | Read data of the selected register |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
On every cycle the assertions check four things. A request always follows an earlier enabled and unmasked pending bit. Pending bits neither vanish without a status write nor appear without a set pulse. A set pulse always survives a clear in the same cycle. The mask changes only on a mask write. Other properties need the bench's scenarios, because they depend on the order of events rather than on a single cycle. These are the exact three-edge latency through the synchroniser, the difference between edge and level lines when an input is held high across an acknowledge, and the opposite acknowledge polarity of the two modes.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    ACK_W1C = 1'b0,
    ACK_W0C = 1'b1
  } ack_mode_e;

  typedef enum logic {
    SEL_MASK   = 1'b0,
    SEL_STATUS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic meta_q, stab_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[i];
        stab_q <= meta_q;
      end
    end
    assign sync_o[i] = stab_q;
  end
endmodule

// File: rtl/irq_trig.sv
module irq_trig #(
  parameter int unsigned      WIDTH     = 32,
  parameter logic [WIDTH-1:0] EDGE_MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] line_i,
  output logic [WIDTH-1:0] set_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= line_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_kind
    if (EDGE_MASK[i]) begin : g_edge
      assign set_o[i] = line_i[i] & ~prev_q[i];
    end else begin : g_level
      assign set_o[i] = line_i[i];
    end
  end
endmodule

// File: rtl/irq_status.sv
module irq_status
  import irq_pkg::*;
#(
  parameter int unsigned WIDTH    = 32,
  parameter ack_mode_e   ACK_MODE = ACK_W1C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic             ack_we_i,
  input  logic [WIDTH-1:0] ack_data_i,
  output logic [WIDTH-1:0] pend_o
);
  logic [WIDTH-1:0] pend_q, clr_vec;

  if (ACK_MODE == ACK_W0C) begin : g_w0c
    assign clr_vec = ack_we_i ? ~ack_data_i : '0;
  end else begin : g_w1c
    assign clr_vec = ack_we_i ? ack_data_i : '0;
  end

  // set has priority over clear so no event is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_vec) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_req.sv
module irq_req #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pend_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic             gie_i,
  output logic             req_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= gie_i & (|(pend_i & mask_i));
  end

  assign req_o = req_q;
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned        NUM_IRQ   = 32,
  parameter logic [NUM_IRQ-1:0] EDGE_MASK = NUM_IRQ'(32'h0000_FFFF),
  parameter ack_mode_e          ACK_MODE  = ACK_W1C
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               gie_i,
  input  logic               reg_we_i,
  input  logic               reg_sel_i,
  input  logic [NUM_IRQ-1:0] reg_wdata_i,
  output logic [NUM_IRQ-1:0] reg_rdata_o,
  output logic               irq_o
);
  logic [NUM_IRQ-1:0] line_sync, set_vec, pend_q, mask_q;
  logic               mask_we, stat_we;

  assign mask_we = reg_we_i & (reg_sel_e'(reg_sel_i) == SEL_MASK);
  assign stat_we = reg_we_i & (reg_sel_e'(reg_sel_i) == SEL_STATUS);

  irq_sync #(.WIDTH(NUM_IRQ)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(irq_i),
    .sync_o (line_sync)
  );

  irq_trig #(.WIDTH(NUM_IRQ), .EDGE_MASK(EDGE_MASK)) u_trig (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(line_sync),
    .set_o (set_vec)
  );

  irq_status #(.WIDTH(NUM_IRQ), .ACK_MODE(ACK_MODE)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_vec),
    .ack_we_i  (stat_we),
    .ack_data_i(reg_wdata_i),
    .pend_o    (pend_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_we) mask_q <= reg_wdata_i;
  end

  irq_req #(.WIDTH(NUM_IRQ)) u_req (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pend_i(pend_q),
    .mask_i(mask_q),
    .gie_i (gie_i),
    .req_o (irq_o)
  );

  assign reg_rdata_o = (reg_sel_e'(reg_sel_i) == SEL_STATUS) ? pend_q : mask_q;
endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk #(
  parameter int unsigned NUM_IRQ = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               gie_i,
  input logic               irq_o,
  input logic [NUM_IRQ-1:0] pend_q,
  input logic [NUM_IRQ-1:0] mask_q,
  input logic [NUM_IRQ-1:0] set_vec,
  input logic               mask_we,
  input logic               stat_we
);
  AST_REQ_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(gie_i)); // R6
  AST_REQ_NEEDS_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|(pend_q & mask_q))); // R1
  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(stat_we) |-> ((pend_q & $past(pend_q)) == $past(pend_q))); // R3
  AST_PEND_ONLY_BY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> ((pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0)); // R12
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> ((pend_q & $past(set_vec)) == $past(set_vec))); // R9
  AST_MASK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(mask_we) |-> $stable(mask_q)); // R2
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .gie_i  (gie_i),
  .irq_o  (irq_o),
  .pend_q (pend_q),
  .mask_q (mask_q),
  .set_vec(set_vec),
  .mask_we(mask_we),
  .stat_we(stat_we)
);

// File: tb/irq_latch_ctrl_tb.sv
module irq_latch_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic        gie = 1'b0;
  logic        we = 1'b0;
  logic        sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, irq_b;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  irq_latch_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .gie_i(gie), .reg_we_i(we),
    .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata_a), .irq_o(irq_a)
  );

  irq_latch_ctrl #(.ACK_MODE(irq_pkg::ACK_W0C)) u_dut_w0c (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .gie_i(gie), .reg_we_i(we),
    .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata_b), .irq_o(irq_b)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(logic s, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0; sel = 1'b1;
  endtask

  task automatic t_reset();
    sel = 1'b0; #1;
    check("R1 mask reset", rdata_a, 32'h0);
    sel = 1'b1; #1;
    check("R1 status reset", rdata_a, 32'h0);
    check("R1 irq reset", {31'h0, irq_a}, 32'h0);
  endtask

  task automatic t_mask();
    reg_write(1'b0, 32'hA5A5_00F0);
    sel = 1'b0; #1;
    check("R2 mask read", rdata_a, 32'hA5A5_00F0);
    reg_write(1'b0, 32'h0000_0003);
    sel = 1'b0; #1;
    check("R2 mask replaced", rdata_a, 32'h0000_0003);
    reg_write(1'b0, 32'h0);
  endtask

  task automatic t_edge_latch();
    gie = 1'b1;
    @(negedge clk);
    irq[3] = 1'b1;
    wait_n(1); check("R11 after edge 1", rdata_a, 32'h0);
    wait_n(1); check("R11 after edge 2", rdata_a, 32'h0);
    wait_n(1); check("R11 after edge 3", rdata_a, 32'h8);
    irq[3] = 1'b0;
    wait_n(3);
    check("R3 sticky after drop", rdata_a, 32'h8);
    check("R8 masked bit readable", rdata_a & 32'h8, 32'h8);
    check("R1 masked no irq", {31'h0, irq_a}, 32'h0);
    reg_write(1'b0, 32'h8);
    check("R5 irq not yet", {31'h0, irq_a}, 32'h0);
    wait_n(1);
    check("R5 irq raised", {31'h0, irq_a}, 32'h1);
  endtask

  task automatic t_gie();
    gie = 1'b0;
    wait_n(1);
    check("R6 gie blocks", {31'h0, irq_a}, 32'h0);
    gie = 1'b1;
    wait_n(1);
    check("R6 gie restores", {31'h0, irq_a}, 32'h1);
  endtask

  task automatic t_w1c();
    reg_write(1'b1, 32'h0);
    check("R4 zero leaves bit", rdata_a, 32'h8);
    check("R4 irq kept", {31'h0, irq_a}, 32'h1);
    reg_write(1'b1, 32'h8);
    check("R4 one clears", rdata_a, 32'h0);
    check("R5 irq still registered", {31'h0, irq_a}, 32'h1);
    wait_n(1);
    check("R5 irq drops", {31'h0, irq_a}, 32'h0);
    irq[3] = 1'b1;
    wait_n(3);
    check("R3 edge held latched", rdata_a, 32'h8);
    reg_write(1'b1, 32'h8);
    wait_n(3);
    check("R3 held edge no reset", rdata_a, 32'h0);
    irq[3] = 1'b0;
    reg_write(1'b0, 32'h0);
    wait_n(3);
  endtask

  task automatic t_level();
    irq[20] = 1'b1;
    wait_n(3);
    check("R7 level latched", rdata_a, 32'h0010_0000);
    reg_write(1'b1, 32'h0010_0000);
    check("R9 set beats clear", rdata_a, 32'h0010_0000);
    irq[20] = 1'b0;
    wait_n(3);
    check("R7 level sticky", rdata_a, 32'h0010_0000);
    reg_write(1'b1, 32'h0010_0000);
    check("R7 level acked", rdata_a, 32'h0);
  endtask

  task automatic t_multi();
    irq = 32'h8000_0021;
    wait_n(3);
    check("R12 lines map to bits", rdata_a, 32'h8000_0021);
    irq = '0;
    wait_n(3);
    reg_write(1'b1, 32'hFFFF_FFFF);
    check("R12 all cleared", rdata_a, 32'h0);
  endtask

  task automatic t_w0c();
    reg_write(1'b1, 32'h0);
    check("R10 zero clears all", rdata_b, 32'h0);
    irq[7] = 1'b1;
    wait_n(3);
    irq[7] = 1'b0;
    check("R10 latched", rdata_b, 32'h80);
    reg_write(1'b1, 32'hFFFF_FFFF);
    check("R10 ones leave bits", rdata_b, 32'h80);
    reg_write(1'b1, 32'hFFFF_FF7F);
    check("R10 zero clears bit", rdata_b, 32'h0);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_mask();
    t_edge_latch();
    t_gie();
    t_w1c();
    t_level();
    t_multi();
    t_w0c();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule